// File: doc/BRIEF.md
# Dithered Output Word-Length Reducer

This block sits at the output of a stereo sample-rate-conversion datapath. It accepts one pair of 24-bit signed samples, left and right, on each strobe. It then requantizes both channels to an output word length of 16, 18, 20 or 24 bits, picked by a 2-bit select. Before the low bits are dropped, triangular-PDF dither is added. The dither is sized to one LSB of the chosen length, and each channel draws it from its own generators.

Each channel has two free-running 16-bit LFSRs, so the block holds four in all. The two uniform values from a channel's pair are masked to the number of dropped bits. Their sum, less a fixed offset, gives a dither value that is symmetric about zero. The dithered value is truncated to the target length and clamped to that length's extreme codes, so it never wraps. The bits below the word length come out as zero. Results appear one clock after the strobe and hold until the next strobe.

Top module: `wlr_top`

## Requirements
- R1: With select 11 (24-bit), each output equals its input sample exactly: no dither is added and no bit changes.
- R2: With select 00 (16-bit), 01 (18-bit) or 10 (20-bit), the lowest 8, 6 or 4 output bits respectively are zero.
- R3: A dithered value above the largest code of the selected length gives that largest code, and one below -2^23 gives -2^23. With input 0x7FFFFF the output is therefore exactly 0x7FFF00 at 16 bits, 0x7FFFC0 at 18 bits and 0x7FFFF0 at 20 bits. With input 0x800000 the output is exactly 0x800000.
- R4: With L = 2^(24-N) for word length N, every output y satisfies floor((x-(L-1))/L)*L <= y <= floor((x+L-1)/L)*L, with both bounds clamped to the range [-2^23, 2^23-L]. The dither amplitude thus follows the select.
- R5: Dither is always applied below 24 bits. A constant input fed repeatedly at 16 bits yields at least two distinct output values.
- R6: The left and right dither are independent. Identical inputs on both channels yield differing left and right outputs on at least some strobes.
- R7: out_valid is high exactly one cycle after each cycle in which in_valid is high. The sample outputs change only in the cycle after a strobe and hold otherwise.
- R8: Synchronous reset drives out_valid and both outputs to zero and reloads all four LFSR seeds. An identical stimulus after each reset therefore reproduces identical outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: one stereo pair present |
| wl_sel | input | 2 | Output word length: 00=16, 01=18, 10=20, 11=24 |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_l | output | 24 | Left requantized sample, low bits zero |
| out_r | output | 24 | Right requantized sample, low bits zero |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 16-bit LFSRs and the four default seeds. At these values every select code is reached, including the widest dither span of plus or minus 255. The full-scale positive and negative inputs are also reached, and there the error window collapses to a single saturated code. The outputs are pseudo-random, so most checks are bounds checks against the dither window rather than exact values. Exact values are checked in the saturated and pass-through cases. The seeds are verified by replaying identical stimulus after two resets.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
  localparam int DW    = 24;        // sample width
  localparam int MAXSH = DW - 16;   // most bits dropped (16-bit mode)
  localparam int DTW   = MAXSH + 2; // signed dither width

  typedef logic [1:0] wl_sel_t;

  typedef struct packed {
    logic [DW-1:0] y;
    logic          hi;
    logic          lo;
  } quant_t;

  // number of low bits removed for a select code
  function automatic int unsigned drop_bits(wl_sel_t s);
    case (s)
      2'b00:   return DW - 16;
      2'b01:   return DW - 18;
      2'b10:   return DW - 20;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] keep_mask(wl_sel_t s);
    return {DW{1'b1}} << drop_bits(s);
  endfunction

  function automatic logic [DW-1:0] top_code(wl_sel_t s);
    return {1'b0, {(DW-1){1'b1}}} & keep_mask(s);
  endfunction

  function automatic logic [DW-1:0] bottom_code();
    return {1'b1, {(DW-1){1'b0}}};
  endfunction

  // triangular dither: a + b - (L-1), each uniform in [0, L-1]
  function automatic logic signed [DTW-1:0] tpdf(logic [MAXSH-1:0] a,
                                                 logic [MAXSH-1:0] b,
                                                 wl_sel_t s);
    logic [MAXSH-1:0] m;
    logic signed [DTW-1:0] r;
    m = ~({MAXSH{1'b1}} << drop_bits(s));
    r = $signed({2'b00, a & m}) + $signed({2'b00, b & m})
        - $signed({2'b00, m});
    return r;
  endfunction

  // add dither, truncate to target length, clamp at extreme codes
  function automatic quant_t requant(logic signed [DW-1:0] x,
                                     logic signed [DTW-1:0] d,
                                     wl_sel_t s);
    logic signed [DW+1:0] xe, de, sum;
    quant_t q;
    xe  = x;
    de  = d;
    sum = xe + de;
    q.hi = 1'b0;
    q.lo = 1'b0;
    q.y  = x;
    if (s != 2'b11) begin
      q.hi = sum > $signed({3'b000, {(DW-1){1'b1}}});
      q.lo = sum < $signed({3'b111, {(DW-1){1'b0}}});
      if (q.hi)      q.y = top_code(s);
      else if (q.lo) q.y = bottom_code();
      else           q.y = sum[DW-1:0] & keep_mask(s);
    end
    return q;
  endfunction
endpackage

// File: rtl/wlr_lfsr.sv
module wlr_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] step(logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= step(state);
  end
endmodule

// File: rtl/wlr_tpdf.sv
module wlr_tpdf
  import wlr_pkg::*;
#(
  parameter int           LW     = 16,
  parameter logic [LW-1:0] SEED_A = 16'hACE1,
  parameter logic [LW-1:0] SEED_B = 16'h1D0F
) (
  input  logic                  clk,
  input  logic                  rst,
  input  wl_sel_t               sel,
  output logic signed [DTW-1:0] dither
);
  localparam logic [LW-1:0] SEEDS [2] = '{SEED_A, SEED_B};

  logic [LW-1:0] st [2];

  for (genvar g = 0; g < 2; g++) begin : g_src
    wlr_lfsr #(.W(LW), .SEED(SEEDS[g])) lfsr_i (
      .clk  (clk),
      .rst  (rst),
      .state(st[g])
    );
  end

  assign dither = tpdf(st[0][MAXSH-1:0], st[1][LW-1:LW-MAXSH], sel);
endmodule

// File: rtl/wlr_chan.sv
module wlr_chan
  import wlr_pkg::*;
#(
  parameter int           LW     = 16,
  parameter logic [LW-1:0] SEED_A = 16'hACE1,
  parameter logic [LW-1:0] SEED_B = 16'h1D0F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  wl_sel_t       sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          sat_hi,
  output logic          sat_lo
);
  logic signed [DTW-1:0] dither;
  quant_t q;

  wlr_tpdf #(.LW(LW), .SEED_A(SEED_A), .SEED_B(SEED_B)) tpdf_i (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .dither(dither)
  );

  assign q      = requant($signed(din), dither, sel);
  assign sat_hi = q.hi;
  assign sat_lo = q.lo;

  always_ff @(posedge clk) begin
    if (rst)           dout <= '0;
    else if (in_valid) dout <= q.y;
  end
endmodule

// File: rtl/wlr_top.sv
module wlr_top
  import wlr_pkg::*;
#(
  parameter int           LW      = 16,
  parameter logic [LW-1:0] SEED_L0 = 16'hACE1,
  parameter logic [LW-1:0] SEED_L1 = 16'h1D0F,
  parameter logic [LW-1:0] SEED_R0 = 16'h5A3C,
  parameter logic [LW-1:0] SEED_R1 = 16'hE7B1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    wl_sel,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  output logic          out_valid,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r
);
  localparam logic [LW-1:0] SA [2] = '{SEED_L0, SEED_R0};
  localparam logic [LW-1:0] SB [2] = '{SEED_L1, SEED_R1};

  logic [DW-1:0] din  [2];
  logic [DW-1:0] dout [2];
  logic [1:0]    sat_hi, sat_lo;

  assign din[0] = in_l;
  assign din[1] = in_r;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wlr_chan #(.LW(LW), .SEED_A(SA[c]), .SEED_B(SB[c])) chan_i (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid),
      .sel     (wl_sel),
      .din     (din[c]),
      .dout    (dout[c]),
      .sat_hi  (sat_hi[c]),
      .sat_lo  (sat_lo[c])
    );
  end

  assign out_l = dout[0];
  assign out_r = dout[1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/wlr_checker.sv
module wlr_checker
  import wlr_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    wl_sel,
  input logic [DW-1:0] in_l,
  input logic [DW-1:0] in_r,
  input logic          out_valid,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r,
  input logic [1:0]    sat_hi,
  input logic [1:0]    sat_lo
);
  logic took;
  assign took = in_valid && !rst;

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(took));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(took) && !$past(rst) |-> $stable(out_l) && $stable(out_r));

  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    $past(took) && $past(wl_sel) == 2'b11 |->
      out_l == $past(in_l) && out_r == $past(in_r));

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(took) |->
      (out_l & ~keep_mask($past(wl_sel))) == '0 &&
      (out_r & ~keep_mask($past(wl_sel))) == '0);

  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (rst)
    $past(took && sat_hi[0]) |-> out_l == top_code($past(wl_sel)));

  assert_sat_lo_R3: assert property (@(posedge clk) disable iff (rst)
    $past(took && sat_lo[1]) |-> out_r == bottom_code());
endmodule

bind wlr_top wlr_checker chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .wl_sel(wl_sel),
  .in_l(in_l), .in_r(in_r), .out_valid(out_valid),
  .out_l(out_l), .out_r(out_r), .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/wlr_top_tb_top.sv
`timescale 1ns/1ps
module wlr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  wl_sel = 2'b00;
  logic [23:0] in_l = '0, in_r = '0;
  logic        out_valid;
  logic [23:0] out_l, out_r;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wlr_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wl_sel(wl_sel),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r)
  );

  // {sel, left, right}
  localparam int NV = 16;
  localparam logic [49:0] VEC [NV] = '{
    {2'b11, 24'h123456, 24'hFEDCBA},
    {2'b11, 24'h7FFFFF, 24'h800000},
    {2'b00, 24'h7FFFFF, 24'h800000},
    {2'b01, 24'h7FFFFF, 24'h800000},
    {2'b10, 24'h7FFFFF, 24'h800000},
    {2'b00, 24'h000000, 24'hFFFFFF},
    {2'b00, 24'h123480, 24'hEDCB7F},
    {2'b01, 24'h000020, 24'hFFFFE0},
    {2'b10, 24'h400008, 24'hC00007},
    {2'b00, 24'h7FFF80, 24'h800080},
    {2'b01, 24'h00ABCD, 24'h55AA55},
    {2'b10, 24'h7FFFF8, 24'h800001},
    {2'b00, 24'h000100, 24'hFFFF00},
    {2'b11, 24'h000001, 24'hFFFFFF},
    {2'b01, 24'h7FFFE0, 24'h80003F},
    {2'b10, 24'h0F0F0F, 24'hF0F0F0}
  };

  function automatic int sh_of(logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 6 : (s == 2'b10) ? 4 : 0;
  endfunction

  function automatic int clampv(int v, int L);
    int top = (1 << 23) - L;
    int bot = -(1 << 23);
    return (v > top) ? top : (v < bot) ? bot : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] s, logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    wl_sel = s; in_l = l; in_r = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic check_one(logic [1:0] s, logic [23:0] x, logic [23:0] y,
                           string side);
    int sh = sh_of(s);
    int L  = 1 << sh;
    int xv = $signed(x);
    int yv = $signed(y);
    int lo = clampv(((xv - (L - 1)) >>> sh) << sh, L);
    int hi = clampv(((xv + (L - 1)) >>> sh) << sh, L);
    if (s == 2'b11)
      check(y == x, {"R1 pass ", side}, y, x);
    else begin
      check((y & (L - 1)) == 0, {"R2 low bits ", side}, y & (L - 1), 0);
      if (lo == hi)
        check(yv == lo, {"R3 saturate ", side}, yv, lo);
      check(yv >= lo && yv <= hi, {"R4 window ", side}, yv, lo);
    end
  endtask

  logic [23:0] rec_l [8];
  logic [23:0] rec_r [8];

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int distinct, differ;
    logic [23:0] first;
    do_reset();
    // R8 reset state
    check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
    check(out_l == 0 && out_r == 0, "R8 reset data", out_l, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][49:48], VEC[i][47:24], VEC[i][23:0]);
      check(out_valid == 1'b1, "R7 valid after strobe", out_valid, 1);
      check_one(VEC[i][49:48], VEC[i][47:24], out_l, "L");
      check_one(VEC[i][49:48], VEC[i][23:0], out_r, "R");
    end

    // R7: valid drops and data holds without strobe
    first = out_l;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid low", out_valid, 0);
    wl_sel = 2'b00; in_l = 24'h333333;
    repeat (3) @(negedge clk);
    check(out_l == first, "R7 hold", out_l, first);

    // R5 dither varies, R6 channels differ
    distinct = 0; differ = 0;
    for (int k = 0; k < 40; k++) begin
      send(2'b00, 24'h001080, 24'h001080);
      check_one(2'b00, 24'h001080, out_l, "L");
      if (k == 0) first = out_l;
      else if (out_l != first) distinct++;
      if (out_l != out_r) differ++;
    end
    check(distinct > 0, "R5 dither varies", distinct, 1);
    check(differ > 0, "R6 channels differ", differ, 1);

    // R8 seeds reloaded: replay after reset
    do_reset();
    for (int k = 0; k < 8; k++) begin
      send(2'b00, 24'h000040, 24'hFFFFC0);
      rec_l[k] = out_l; rec_r[k] = out_r;
    end
    do_reset();
    for (int k = 0; k < 8; k++) begin
      send(2'b00, 24'h000040, 24'hFFFFC0);
      check(out_l == rec_l[k] && out_r == rec_r[k], "R8 replay",
            out_l, rec_l[k]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule